// File: doc/BRIEF.md
# Streaming 3x3 Mask Convolution Pipeline

This block filters a raster-order pixel stream with a programmable 3x3 coefficient mask, for example an edge detector. It takes one pixel per clock when `s_valid` is high and gives one result for every accepted pixel. Two on-chip line stores keep the two rows above the current row, so the block never holds a whole frame.

The nine products of a neighbourhood are summed by a serial chain of nine multiply-accumulate stages. Each stage adds one tap's product to a partial sum that travels with its pixel. The chain runs at full input rate with a fixed latency counted in accepted pixels. When `s_valid` is low, everything holds, so a result stays tied to its pixel across any gap.

Each result carries two tags. One marks whether the neighbourhood lay fully inside the image. The other marks the last column of a line. Coefficients are written through a small index/data port while the stream is idle.

Top module: `conv3_filter`

## Requirements
- R1: A pixel is accepted only on a clock edge where `s_valid` is high. After an edge with `s_valid` low, `m_valid` is low and `m_data`, `m_win_ok` and `m_eol` keep their previous values.
- R2: Every accepted pixel produces exactly one `m_valid` strobe, in order. The result for the n-th accepted pixel is presented, with `m_valid` high, in the cycle after the (n+9)-th accept. After reset, no strobe comes before the 10th accept.
- R3: For the pixel at row r and column c, the result is the sum over taps k = 3*i + j (i, j in 0..2) of coef[k] times the pixel at row r-2+i and column c-2+j. Pixels are unsigned and coefficients are 4-bit two's complement. `m_data` is a PIX_W+COEF_W+5 bit two's complement value, wide enough that all-(-8) and all-(+7) masks on all-255 pixels do not overflow.
- R4: After reset, tap 4 is +1 and all other taps are 0, so the result equals the pixel one row up and one column left.
- R5: A write with `coef_we` high and `coef_idx` in 0..8 sets that tap to `coef_data`. Writes with `coef_idx` 9 to 15 change nothing. New values apply to accumulations on later accepts, so loads are made while the stream is idle and the pipeline has been flushed.
- R6: `m_win_ok` is high exactly when the result's pixel has row >= 2 and column >= 2 in the current frame. `m_data` is meaningful only then.
- R7: `m_eol` is high exactly for results whose pixel sits in column LINE_W-1.
- R8: A pixel accepted with `s_sof` high is row 0, column 0 of a new frame, even in the middle of a line. After reset the first accepted pixel is row 0, column 0 without `s_sof`.
- R9: After reset, `m_valid`, `m_win_ok`, `m_eol` and `m_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input pixel present; low stalls the whole block |
| s_sof | input | 1 | Marks the pixel as the first of a frame |
| s_pix | input | PIX_W | Unsigned input pixel |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Tap index of the write, 0..8 |
| coef_data | input | COEF_W | Signed coefficient value |
| m_valid | output | 1 | One-cycle strobe per result |
| m_win_ok | output | 1 | Neighbourhood lies fully inside the image |
| m_eol | output | 1 | Result belongs to the last column of a line |
| m_data | output | PIX_W+COEF_W+5 | Signed filtered value |

## Verification
The hardest case to reach is a stall that freezes partial sums across several accumulator stages. The pipeline then resumes, and every in-flight result must still pair with the correct neighbourhood and coefficients. A frame restart in the middle of a line must also drop row history without disturbing results still in flight. The stimulus inserts random gaps of one to three idle cycles between pixels and a seven-cycle stall in mid-frame. It restarts a frame partway through its second row. Before each coefficient load, it pushes the tail of the previous frame out with a short dummy frame whose results all fall outside the window.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int TAPS  = 9;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic vld;
    logic ok;
    logic eol;
  } pix_tag_t;
endpackage

// File: rtl/conv3_coef_bank.sv
module conv3_coef_bank import conv3_pkg::*; #(
  parameter int COEF_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [COEF_W-1:0]             wr_val,
  output logic [TAPS-1:0][COEF_W-1:0]   coef
);
  localparam int CENTER = TAPS / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++)
        coef[k] <= (k == CENTER) ? COEF_W'(1) : '0;
    end else if (wr_en) begin
      for (int k = 0; k < TAPS; k++)
        if (wr_idx == IDX_W'(k)) coef[k] <= wr_val;
    end
  end
endmodule

// File: rtl/conv3_line_store.sv
module conv3_line_store import conv3_pkg::*; #(
  parameter int LINE_W = 640,
  parameter int PIX_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             sof,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_q,
  output logic [PIX_W-1:0] up1_q,
  output logic [PIX_W-1:0] up2_q,
  output pix_tag_t         tag_q
);
  localparam int COL_W    = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int LAST_COL = LINE_W - 1;

  // each entry: {row two above, row one above} for one column
  logic [2*PIX_W-1:0] mem [LINE_W];
  logic [2*PIX_W-1:0] rd_q;
  logic [COL_W-1:0]   col_cnt, cur_col, col_q;
  logic [1:0]         row_lvl, cur_lvl;
  logic               last_col;

  always_comb begin
    cur_col  = sof ? '0 : col_cnt;
    cur_lvl  = sof ? '0 : row_lvl;
    last_col = (cur_col == COL_W'(LAST_COL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_cnt <= '0;
      row_lvl <= '0;
      tag_q   <= '0;
    end else if (adv) begin
      if (last_col) begin
        col_cnt <= '0;
        row_lvl <= (cur_lvl == 2'd2) ? 2'd2 : cur_lvl + 2'd1;
      end else begin
        col_cnt <= cur_col + COL_W'(1);
        row_lvl <= cur_lvl;
      end
      tag_q <= '{vld: 1'b1,
                 ok:  (cur_lvl == 2'd2) && (cur_col >= COL_W'(2)),
                 eol: last_col};
    end
  end

  // read now, write the column back one accept later
  always_ff @(posedge clk) begin
    if (adv) begin
      rd_q  <= mem[cur_col];
      pix_q <= pix_in;
      col_q <= cur_col;
      if (tag_q.vld) mem[col_q] <= {rd_q[PIX_W-1:0], pix_q};
    end
  end

  assign up2_q = rd_q[2*PIX_W-1:PIX_W];
  assign up1_q = rd_q[PIX_W-1:0];
endmodule

// File: rtl/conv3_window.sv
module conv3_window import conv3_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic                        clk,
  input  logic                        adv,
  input  logic [PIX_W-1:0]            pix,
  input  logic [PIX_W-1:0]            up1,
  input  logic [PIX_W-1:0]            up2,
  output logic [TAPS-1:0][PIX_W-1:0]  win
);
  // index 0 = two rows up, 2 = current row
  logic [2:0][PIX_W-1:0] col_new, col_m1, col_m2;

  assign col_new = {pix, up1, up2};

  always_ff @(posedge clk) begin
    if (adv) begin
      col_m2 <= col_m1;
      col_m1 <= col_new;
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      win[3*i + 0] = col_m2[i];
      win[3*i + 1] = col_m1[i];
      win[3*i + 2] = col_new[i];
    end
  end
endmodule

// File: rtl/conv3_tap_delay.sv
module conv3_tap_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (adv) begin
      sr[0] <= d;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/conv3_mac_stage.sv
module conv3_mac_stage import conv3_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 4,
  parameter int ACC_W  = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [COEF_W-1:0]       coef,
  input  logic [PIX_W-1:0]        px,
  input  logic signed [ACC_W-1:0] acc_in,
  input  pix_tag_t                tag_in,
  output logic signed [ACC_W-1:0] acc_out,
  output pix_tag_t                tag_out
);
  localparam int PROD_W = PIX_W + COEF_W + 1;

  logic signed [PIX_W:0]    px_s;
  logic signed [COEF_W-1:0] cf_s;
  logic signed [PROD_W-1:0] prod;

  assign px_s = {1'b0, px};
  assign cf_s = coef;
  assign prod = PROD_W'(px_s) * PROD_W'(cf_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      tag_out <= '0;
    end else if (adv) begin
      acc_out <= acc_in + ACC_W'(prod);
      tag_out <= tag_in;
    end
  end
endmodule

// File: rtl/conv3_filter.sv
module conv3_filter import conv3_pkg::*; #(
  parameter int LINE_W  = 640,
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 4,
  localparam int ACC_W  = PIX_W + COEF_W + 1 + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic [PIX_W-1:0]  s_pix,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [COEF_W-1:0] coef_data,
  output logic              m_valid,
  output logic              m_win_ok,
  output logic              m_eol,
  output logic [ACC_W-1:0]  m_data
);
  logic                       adv, adv_q;
  logic [PIX_W-1:0]           ls_pix, ls_up1, ls_up2;
  pix_tag_t                   ls_tag;
  logic [TAPS-1:0][PIX_W-1:0] win_next;
  logic [TAPS-1:0][COEF_W-1:0] coef_q;
  logic [PIX_W-1:0]           tap_px [TAPS];
  logic signed [ACC_W-1:0]    acc_c  [TAPS+1];
  pix_tag_t                   tag_c  [TAPS+1];

  assign adv = s_valid;

  conv3_coef_bank #(.COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst(rst), .wr_en(coef_we), .wr_idx(coef_idx),
    .wr_val(coef_data), .coef(coef_q)
  );

  conv3_line_store #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_lines (
    .clk(clk), .rst(rst), .adv(adv), .sof(s_sof), .pix_in(s_pix),
    .pix_q(ls_pix), .up1_q(ls_up1), .up2_q(ls_up2), .tag_q(ls_tag)
  );

  conv3_window #(.PIX_W(PIX_W)) u_win (
    .clk(clk), .adv(adv), .pix(ls_pix), .up1(ls_up1), .up2(ls_up2),
    .win(win_next)
  );

  // tap k is consumed by stage k, k accepts after the window forms
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_direct
      assign tap_px[k] = win_next[k];
    end else begin : g_delay
      conv3_tap_delay #(.W(PIX_W), .DEPTH(k)) u_dly (
        .clk(clk), .adv(adv), .d(win_next[k]), .q(tap_px[k])
      );
    end
  end

  assign acc_c[0] = '0;
  assign tag_c[0] = ls_tag;

  for (genvar s = 0; s < TAPS; s++) begin : g_stage
    conv3_mac_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst), .adv(adv),
      .coef(coef_q[s]), .px(tap_px[s]),
      .acc_in(acc_c[s]), .tag_in(tag_c[s]),
      .acc_out(acc_c[s+1]), .tag_out(tag_c[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) adv_q <= 1'b0;
    else     adv_q <= adv;
  end

  assign m_valid  = adv_q & tag_c[TAPS].vld;
  assign m_win_ok = tag_c[TAPS].ok;
  assign m_eol    = tag_c[TAPS].eol;
  assign m_data   = acc_c[TAPS];
endmodule

// File: rtl/conv3_filter_chk.sv
module conv3_filter_chk #(
  parameter int ACC_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             m_valid,
  input logic             m_win_ok,
  input logic             m_eol,
  input logic [ACC_W-1:0] m_data
);
  logic [3:0] fill_cnt;
  logic [1:0] col_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      col_seen <= '0;
    end else begin
      if (s_valid && fill_cnt != 4'hF) fill_cnt <= fill_cnt + 4'd1;
      if (m_valid) begin
        if (m_eol)                 col_seen <= '0;
        else if (col_seen != 2'd3) col_seen <= col_seen + 2'd1;
      end
    end
  end

  AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> $past(s_valid)); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(s_valid) |-> !m_valid && $stable(m_data) && $stable(m_win_ok) && $stable(m_eol)); // R1

  AST_PIPE_FILL: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> fill_cnt >= 4'd10); // R2

  AST_WINDOW_COLUMNS: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_win_ok) |-> col_seen >= 2'd2); // R6
endmodule

bind conv3_filter conv3_filter_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .m_valid(m_valid),
  .m_win_ok(m_win_ok), .m_eol(m_eol), .m_data(m_data)
);

// File: tb/conv3_filter_tb.sv
`timescale 1ns/1ps
module conv3_filter_tb;
  localparam int LW = 6;
  localparam int PW = 8;
  localparam int CW = 4;
  localparam int AW = PW + CW + 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_sof = 1'b0;
  logic [PW-1:0] s_pix = '0;
  logic          coef_we = 1'b0;
  logic [3:0]    coef_idx = '0;
  logic [CW-1:0] coef_data = '0;
  logic          m_valid, m_win_ok, m_eol;
  logic [AW-1:0] m_data;

  always #10 clk = ~clk;

  conv3_filter #(.LINE_W(LW), .PIX_W(PW), .COEF_W(CW)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_sof(s_sof), .s_pix(s_pix),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .m_valid(m_valid), .m_win_ok(m_win_ok), .m_eol(m_eol), .m_data(m_data)
  );

  typedef struct { int val; bit ok; bit eol; } exp_t;

  int    n_checks = 0;
  int    n_err = 0;
  bit    done = 0;
  bit    armed = 0;
  exp_t  q[$];
  int    mc[9];
  int    img[32][LW];
  int    b_row, b_col, n_acc;
  bit    acc_flag;
  string phase = "R4";
  logic [AW-1:0] prev_data;
  logic  prev_ok, prev_eol;
  bit    have_prev = 0;

  task automatic check(bit cond, string req, string what, longint act, longint exp);
    n_checks++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: sees accepted pixels and coefficient writes
  always @(posedge clk) begin
    int r, c;
    exp_t e;
    if (rst) begin
      q.delete();
      n_acc = 0; b_row = 0; b_col = 0; acc_flag = 0;
      for (int k = 0; k < 9; k++) mc[k] = (k == 4) ? 1 : 0;
    end else begin
      acc_flag = s_valid;
      if (coef_we && coef_idx < 4'd9) mc[coef_idx] = int'($signed(coef_data));
      if (s_valid) begin
        if (s_sof) begin b_row = 0; b_col = 0; end
        r = b_row; c = b_col;
        img[r][c] = int'(s_pix);
        e.ok  = (r >= 2) && (c >= 2);
        e.eol = (c == LW - 1);
        e.val = 0;
        if (e.ok)
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
              e.val += mc[3*i + j] * img[r-2+i][c-2+j];
        q.push_back(e);
        n_acc++;
        if (c == LW - 1) begin b_col = 0; b_row = (r < 31) ? r + 1 : r; end
        else b_col = c + 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit ev;
    exp_t e;
    if (armed && !rst) begin
      ev = acc_flag && (n_acc >= 10);
      check(m_valid === ev, acc_flag ? "R2" : "R1", "m_valid", longint'(m_valid), longint'(ev));
      if (m_valid) begin
        check(q.size() == 10, "R2", "results in flight", q.size(), 10);
        if (q.size() > 0) begin
          e = q.pop_front();
          check(m_win_ok === e.ok, "R6", "m_win_ok", longint'(m_win_ok), longint'(e.ok));
          check(m_eol === e.eol, "R7", "m_eol", longint'(m_eol), longint'(e.eol));
          if (e.ok)
            check(longint'($signed(m_data)) == longint'(e.val), phase, "m_data",
                  longint'($signed(m_data)), longint'(e.val));
        end
      end
      if (!acc_flag && have_prev)
        check(m_data === prev_data && m_win_ok === prev_ok && m_eol === prev_eol,
              "R1", "held m_data", longint'($signed(m_data)), longint'($signed(prev_data)));
      prev_data = m_data; prev_ok = m_win_ok; prev_eol = m_eol; have_prev = 1;
    end
  end

  task automatic send_px(bit sof, int v);
    s_valid = 1'b1; s_sof = sof; s_pix = PW'(v);
    @(posedge clk); #1;
    s_sof = 1'b0;
  endtask

  task automatic idle(int n);
    s_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_coef(int idx, int val);
    coef_we = 1'b1; coef_idx = 4'(idx); coef_data = CW'(val);
    @(posedge clk); #1;
    coef_we = 1'b0;
  endtask

  task automatic send_frame(int rows, bit sof, bit sat, int gap);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < LW; c++) begin
        send_px(sof && r == 0 && c == 0, sat ? 255 : int'($urandom_range(0, 255)));
        if (gap > 0 && $urandom_range(0, gap - 1) == 0) idle(int'($urandom_range(1, 3)));
      end
  endtask

  // pushes earlier results out with a frame whose outputs are all off-window
  task automatic flush();
    for (int k = 0; k < 10; k++) send_px(k == 0, int'($urandom_range(0, 255)));
    idle(2);
  endtask

  task automatic load_mask(int m0, int m1, int m2, int m3, int m4, int m5, int m6, int m7, int m8);
    put_coef(0, m0); put_coef(1, m1); put_coef(2, m2);
    put_coef(3, m3); put_coef(4, m4); put_coef(5, m5);
    put_coef(6, m6); put_coef(7, m7); put_coef(8, m8);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(m_valid === 1'b0, "R9", "m_valid after reset", longint'(m_valid), 0);
    check(m_win_ok === 1'b0, "R9", "m_win_ok after reset", longint'(m_win_ok), 0);
    check(m_eol === 1'b0, "R9", "m_eol after reset", longint'(m_eol), 0);
    check(m_data === '0, "R9", "m_data after reset", longint'(m_data), 0);
    armed = 1;
    @(posedge clk); #1;

    // R4 and R8: reset mask, first frame without a start flag
    phase = "R4";
    send_frame(5, 1'b0, 1'b0, 0);
    flush();

    // R5: edge mask, out-of-range indices ignored, gaps in the stream (R1)
    phase = "R5";
    load_mask(-1, 0, 1, -2, 0, 2, -1, 0, 1);
    for (int k = 9; k < 16; k++) put_coef(k, 7);
    send_frame(6, 1'b1, 1'b0, 3);
    flush();

    // R3: extreme sums
    phase = "R3";
    load_mask(-8, -8, -8, -8, -8, -8, -8, -8, -8);
    send_frame(4, 1'b1, 1'b1, 0);
    flush();
    load_mask(7, 7, 7, 7, 7, 7, 7, 7, 7);
    send_frame(4, 1'b1, 1'b1, 2);
    flush();

    // R8: restart mid-line, with a long stall (R1)
    phase = "R8";
    load_mask(1, 2, -3, 0, 4, -1, 5, -6, 3);
    for (int c = 0; c < LW; c++) send_px(c == 0, int'($urandom_range(0, 255)));
    for (int c = 0; c < 3; c++) send_px(1'b0, int'($urandom_range(0, 255)));
    idle(7);
    send_frame(5, 1'b1, 1'b0, 4);
    flush();

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule